// File: doc/BRIEF.md
# Cache-Aware Write Command Selector

This block sits beside the write side of a DMA engine and decides, one burst at a time, which PCI write command to use and how many dwords each outbound burst carries. Each time the engine asks for a decision, the block looks at the configuration enables, the programmed cache line size, the burst cap, the low bits of the current source and destination addresses, the dwords still to move and the FIFO fill level. One clock later it presents a command code and a burst length, together with a one-cycle start strobe.

When cache mode is usable, the block first issues plain writes that bring the destination up to a cache line boundary. From that point it issues Memory Write and Invalidate bursts whose length is the largest whole number of lines that fits both the remaining data and the cap. The engine asks again after every burst, so the bursts shrink toward a single line near the end of a long move. Any tail shorter than one line goes out as a plain write.

A memory-to-memory move whose source and destination sit at different offsets within a line can never be aligned on both sides. The block detects this when the transfer starts and stays out of cache mode for the whole transfer. Addresses and counts are dword granular.

Top module: `wcs_write_cmd_sel`

## Requirements
- R1: Memory Write and Invalidate (code 0xF) is chosen only when all three enables are high: the line-size enable, the write-invalidate enable and the PCI command register write-invalidate bit. Otherwise Memory Write (code 0x7) is used.
- R2: The line size is usable only if it is 2, 4, 8, 16, 32, 64 or 128 dwords and does not exceed the burst cap. Any other setting gives Memory Write with length min(remaining, cap).
- R3: Memory Write and Invalidate also requires the FIFO to hold at least one line of dwords. With too little data in the FIFO, the burst keeps its line-multiple length but uses code 0x7.
- R4: In cache mode, if the destination dword offset within a line (address bits above bit 1, modulo the line size) is nonzero, the burst is Memory Write with length min(line - offset, remaining, cap).
- R5: On a transfer start pulse with the memory-move flag high, a byte offset within a line that differs between source and destination disables cache mode for every decision until the next start pulse. During such a transfer all bursts are Memory Write with length min(remaining, cap).
- R6: In cache mode with an aligned destination and at least one line to send, the length is the largest multiple of the line size not above min(remaining, cap). Because of this, equal cap and line size always give single-line bursts.
- R7: In cache mode with an aligned destination and less than one line remaining, the burst is Memory Write carrying the whole remainder.
- R8: Every burst length is at most the cap and at most the remaining dword count.
- R9: A request sampled at a clock edge updates the command and length at that edge. The start strobe is high for exactly that one following cycle, and only if the length is nonzero.
- R10: After reset, the start strobe is low, the command is 0x7 and the length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_en_i | input | 1 | Cache line size enable |
| wr_inv_en_i | input | 1 | Write-invalidate enable |
| pci_mwi_en_i | input | 1 | PCI command register write-invalidate bit |
| line_dw_i | input | BURST_W | Cache line size in dwords |
| max_burst_i | input | BURST_W | Burst cap in dwords |
| mem_move_i | input | 1 | Transfer is memory to memory |
| src_off_i | input | BURST_W+1 | Low byte-address bits of the read pointer |
| dst_off_i | input | BURST_W+1 | Low byte-address bits of the write pointer |
| rem_dw_i | input | CNT_W | Dwords left to write |
| fifo_dw_i | input | FIFO_W | Dwords held in the DMA FIFO |
| xfer_start_i | input | 1 | Pulse at the start of a transfer |
| req_i | input | 1 | Request a decision for the next burst |
| start_o | output | 1 | One-cycle burst start strobe |
| cmd_o | output | 4 | PCI command code (0x7 or 0xF) |
| len_o | output | BURST_W | Burst length in dwords |

## Verification
The bench uses the default widths: 8-bit line size and cap, which reach the full set of legal line sizes up to 128 dwords, and 9-bit address offsets, which cover every position within the largest line. The 16-bit remaining count allows transfers many lines long, so one long move walks through the alignment burst, the capped bursts, the shrinking multiples and the tail. The 8-bit FIFO level lets random fills land on both sides of every line size.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  typedef enum logic [3:0] {
    CMD_MW  = 4'h7,
    CMD_MWI = 4'hF
  } wcs_cmd_e;

  // A line size is usable when it is a power of two of at least 2.
  function automatic logic line_is_pow2(input logic [7:0] dw);
    return (dw >= 8'd2) && ((dw & (dw - 8'd1)) == 8'd0);
  endfunction

  // Round a dword count down to a multiple of a power-of-two line.
  function automatic logic [7:0] floor_to_line(input logic [7:0] val, input logic [7:0] line);
    return val & ~(line - 8'd1);
  endfunction

  function automatic logic [7:0] min8(input logic [7:0] a, input logic [7:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/wcs_cfg_check.sv
module wcs_cfg_check #(
  parameter int BURST_W = 8
) (
  input  logic               line_en_i,
  input  logic               wr_inv_en_i,
  input  logic               pci_mwi_en_i,
  input  logic [BURST_W-1:0] line_dw_i,
  input  logic [BURST_W-1:0] max_burst_i,
  output logic               line_legal_o,
  output logic               enables_o
);
  import wcs_pkg::*;

  always_comb begin
    line_legal_o = line_is_pow2(8'(line_dw_i)) && (line_dw_i <= max_burst_i);
    enables_o    = line_en_i && wr_inv_en_i && pci_mwi_en_i;
  end

endmodule

// File: rtl/wcs_align_track.sv
module wcs_align_track #(
  parameter int BURST_W = 8,
  localparam int OFF_W  = BURST_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_start_i,
  input  logic               mem_move_i,
  input  logic [BURST_W-1:0] line_dw_i,
  input  logic [OFF_W-1:0]   src_off_i,
  input  logic [OFF_W-1:0]   dst_off_i,
  output logic               mismatch_o
);
  logic [OFF_W-1:0]   off_diff;
  logic [BURST_W-1:0] line_diff;
  logic               mismatch_now;
  logic               mismatch_q;

  always_comb begin
    off_diff     = src_off_i ^ dst_off_i;
    line_diff    = BURST_W'(off_diff[OFF_W-1:2]) & (line_dw_i - 1'b1);
    mismatch_now = mem_move_i && ((off_diff[1:0] != 2'b00) || (line_diff != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mismatch_q <= 1'b0;
    else if (xfer_start_i) mismatch_q <= mismatch_now;
  end

  // A start in the same cycle as a request already sees its own verdict.
  assign mismatch_o = xfer_start_i ? mismatch_now : mismatch_q;

  // R5
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start_i |=> mismatch_q == $past(mismatch_q));

endmodule

// File: rtl/wcs_burst_calc.sv
module wcs_burst_calc #(
  parameter int BURST_W = 8,
  parameter int CNT_W   = 16,
  parameter int FIFO_W  = 8,
  localparam int OFF_W  = BURST_W + 1
) (
  input  logic               cache_on_i,
  input  logic               enables_i,
  input  logic [BURST_W-1:0] line_dw_i,
  input  logic [BURST_W-1:0] max_burst_i,
  input  logic [OFF_W-1:0]   dst_off_i,
  input  logic [CNT_W-1:0]   rem_dw_i,
  input  logic [FIFO_W-1:0]  fifo_dw_i,
  output logic [3:0]         cmd_o,
  output logic [BURST_W-1:0] len_o,
  output logic               aligned_o,
  output logic               tail_o
);
  import wcs_pkg::*;

  logic [BURST_W-1:0] cap;
  logic [BURST_W-1:0] dst_line_off;
  logic [BURST_W-1:0] to_boundary;
  logic               fifo_full_line;

  always_comb begin
    cap            = (rem_dw_i < CNT_W'(max_burst_i)) ? rem_dw_i[BURST_W-1:0] : max_burst_i;
    dst_line_off   = BURST_W'(dst_off_i[OFF_W-1:2]) & (line_dw_i - 1'b1);
    to_boundary    = line_dw_i - dst_line_off;
    aligned_o      = (dst_line_off == '0);
    fifo_full_line = FIFO_W'(line_dw_i) <= fifo_dw_i;
    tail_o         = cap < line_dw_i;

    cmd_o = CMD_MW;
    len_o = cap;
    if (cache_on_i) begin
      if (!aligned_o) begin
        len_o = BURST_W'(min8(8'(to_boundary), 8'(cap)));
      end else if (!tail_o) begin
        len_o = BURST_W'(floor_to_line(8'(cap), 8'(line_dw_i)));
        if (enables_i && fifo_full_line) cmd_o = CMD_MWI;
      end
    end
  end

endmodule

// File: rtl/wcs_write_cmd_sel.sv
module wcs_write_cmd_sel #(
  parameter int BURST_W = 8,
  parameter int CNT_W   = 16,
  parameter int FIFO_W  = 8,
  localparam int OFF_W  = BURST_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_en_i,
  input  logic               wr_inv_en_i,
  input  logic               pci_mwi_en_i,
  input  logic [BURST_W-1:0] line_dw_i,
  input  logic [BURST_W-1:0] max_burst_i,
  input  logic               mem_move_i,
  input  logic [OFF_W-1:0]   src_off_i,
  input  logic [OFF_W-1:0]   dst_off_i,
  input  logic [CNT_W-1:0]   rem_dw_i,
  input  logic [FIFO_W-1:0]  fifo_dw_i,
  input  logic               xfer_start_i,
  input  logic               req_i,
  output logic               start_o,
  output logic [3:0]         cmd_o,
  output logic [BURST_W-1:0] len_o
);
  import wcs_pkg::*;

  logic               line_legal;
  logic               enables;
  logic               mismatch;
  logic               cache_on;
  logic               aligned;
  logic               tail;
  logic [3:0]         cmd_next;
  logic [BURST_W-1:0] len_next;

  wcs_cfg_check #(.BURST_W(BURST_W)) u_cfg (
    .line_en_i    (line_en_i),
    .wr_inv_en_i  (wr_inv_en_i),
    .pci_mwi_en_i (pci_mwi_en_i),
    .line_dw_i    (line_dw_i),
    .max_burst_i  (max_burst_i),
    .line_legal_o (line_legal),
    .enables_o    (enables)
  );

  wcs_align_track #(.BURST_W(BURST_W)) u_align (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_start_i (xfer_start_i),
    .mem_move_i   (mem_move_i),
    .line_dw_i    (line_dw_i),
    .src_off_i    (src_off_i),
    .dst_off_i    (dst_off_i),
    .mismatch_o   (mismatch)
  );

  assign cache_on = line_legal && !mismatch;

  wcs_burst_calc #(.BURST_W(BURST_W), .CNT_W(CNT_W), .FIFO_W(FIFO_W)) u_calc (
    .cache_on_i  (cache_on),
    .enables_i   (enables),
    .line_dw_i   (line_dw_i),
    .max_burst_i (max_burst_i),
    .dst_off_i   (dst_off_i),
    .rem_dw_i    (rem_dw_i),
    .fifo_dw_i   (fifo_dw_i),
    .cmd_o       (cmd_next),
    .len_o       (len_next),
    .aligned_o   (aligned),
    .tail_o      (tail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      cmd_o   <= CMD_MW;
      len_o   <= '0;
    end else begin
      start_o <= req_i && (len_next != '0);
      if (req_i) begin
        cmd_o <= cmd_next;
        len_o <= len_next;
      end
    end
  end

  // R1
  mwi_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && cmd_o == CMD_MWI |-> $past(line_en_i && wr_inv_en_i && pci_mwi_en_i));

  // R3
  mwi_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && cmd_o == CMD_MWI |-> FIFO_W'($past(line_dw_i)) <= $past(fifo_dw_i));

  // R6
  mwi_multiple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && cmd_o == CMD_MWI |-> (len_o & ($past(line_dw_i) - 1'b1)) == '0);

  // R8
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> len_o <= $past(max_burst_i) && CNT_W'(len_o) <= $past(rem_dw_i));

  // R9
  start_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(req_i) && len_o != '0);

  // R7
  tail_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && aligned && tail |=> cmd_o == CMD_MW);

endmodule

// File: tb/tb_wcs_write_cmd_sel.sv
module tb_wcs_write_cmd_sel;
  localparam int BURST_W = 8;
  localparam int CNT_W   = 16;
  localparam int FIFO_W  = 8;
  localparam int OFF_W   = BURST_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_en, wr_inv_en, pci_mwi_en, mem_move, xfer_start, req;
  logic [BURST_W-1:0] line_dw, max_burst;
  logic [OFF_W-1:0]   src_off, dst_off;
  logic [CNT_W-1:0]   rem_dw;
  logic [FIFO_W-1:0]  fifo_dw;
  logic               start;
  logic [3:0]         cmd;
  logic [BURST_W-1:0] len;

  int checks = 0;
  int failures = 0;
  bit model_mismatch = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wcs_write_cmd_sel #(.BURST_W(BURST_W), .CNT_W(CNT_W), .FIFO_W(FIFO_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_en_i(line_en), .wr_inv_en_i(wr_inv_en),
    .pci_mwi_en_i(pci_mwi_en), .line_dw_i(line_dw), .max_burst_i(max_burst),
    .mem_move_i(mem_move), .src_off_i(src_off), .dst_off_i(dst_off),
    .rem_dw_i(rem_dw), .fifo_dw_i(fifo_dw), .xfer_start_i(xfer_start),
    .req_i(req), .start_o(start), .cmd_o(cmd), .len_o(len)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit legal_line(input int l, input int m);
    return (l == 2 || l == 4 || l == 8 || l == 16 || l == 32 || l == 64 || l == 128) && l <= m;
  endfunction

  function automatic void model(output int e_len, output int e_cmd);
    int l, m, cap, off;
    bit cache;
    l = int'(line_dw); m = int'(max_burst);
    cap = (int'(rem_dw) < m) ? int'(rem_dw) : m;
    cache = legal_line(l, m) && !model_mismatch;
    e_cmd = 7; e_len = cap;
    if (cache) begin
      off = (int'(dst_off) / 4) % l;
      if (off != 0) e_len = (l - off < cap) ? l - off : cap;
      else if (cap >= l) begin
        e_len = (cap / l) * l;
        if (line_en && wr_inv_en && pci_mwi_en && int'(fifo_dw) >= l) e_cmd = 15;
      end
    end
  endfunction

  task automatic begin_xfer();
    int lb;
    lb = int'(line_dw) * 4;
    model_mismatch = 1'b0;
    if (mem_move && lb > 0) model_mismatch = (int'(src_off) % lb) != (int'(dst_off) % lb);
    if (mem_move && lb == 0) model_mismatch = int'(src_off) != int'(dst_off);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic decide(input string tag, output int got_len);
    int e_len, e_cmd;
    model(e_len, e_cmd);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check({tag, " R9 start"}, int'(start), (e_len != 0) ? 1 : 0);
    check({tag, " R8 len"}, int'(len), e_len);
    check({tag, " R1 cmd"}, int'(cmd), e_cmd);
    got_len = int'(len);
    @(negedge clk);
    check({tag, " R9 one-shot"}, int'(start), 0);
  endtask

  task automatic set_cfg(input bit a, input bit b, input bit c, input int l, input int m, input int f);
    line_en = a; wr_inv_en = b; pci_mwi_en = c;
    line_dw = BURST_W'(l); max_burst = BURST_W'(m); fifo_dw = FIFO_W'(f);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int got;
    int l_opts[10] = '{1, 2, 3, 4, 8, 16, 32, 64, 128, 0};
    void'($urandom(32'h5EED_0A17));
    set_cfg(1, 1, 1, 8, 64, 255);
    mem_move = 0; xfer_start = 0; req = 0;
    src_off = '0; dst_off = '0; rem_dw = '0;
    repeat (3) @(negedge clk);
    check("R10 reset start", int'(start), 0);
    check("R10 reset cmd", int'(cmd), 7);
    check("R10 reset len", int'(len), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: one enable off
    set_cfg(1, 1, 0, 8, 64, 255); rem_dw = 40; begin_xfer();
    decide("R1 pci bit off", got);
    check("R1 plain len", got, 40);
    // R2: illegal size and size above cap
    set_cfg(1, 1, 1, 12, 64, 255); rem_dw = 40; begin_xfer();
    decide("R2 illegal line", got);
    set_cfg(1, 1, 1, 16, 8, 255); rem_dw = 40; begin_xfer();
    decide("R2 line above cap", got);
    // R3: FIFO short of a line
    set_cfg(1, 1, 1, 16, 64, 15); rem_dw = 40; begin_xfer();
    decide("R3 fifo short", got);
    check("R3 line multiple kept", got, 32);
    // R4: destination three dwords into an 8-dword line
    set_cfg(1, 1, 1, 8, 64, 255); dst_off = 9'h00C; rem_dw = 40; begin_xfer();
    decide("R4 unaligned", got);
    check("R4 to boundary", got, 5);
    // R6: cap equal to line gives one line
    set_cfg(1, 1, 1, 16, 16, 255); dst_off = 9'h040; rem_dw = 100; begin_xfer();
    decide("R6 cap equals line", got);
    check("R6 single line", got, 16);
    // R7: tail
    set_cfg(1, 1, 1, 8, 64, 255); dst_off = 9'h020; rem_dw = 5; begin_xfer();
    decide("R7 tail", got);
    // R9: zero length means no strobe
    rem_dw = 0; decide("R9 empty", got);

    // R5: mismatched memory move, then a move across many bursts
    for (int pass = 0; pass < 2; pass++) begin
      set_cfg(1, 1, 1, 8, 64, 255);
      mem_move = 1; dst_off = 9'h00C;
      src_off = (pass == 0) ? 9'h01C : 9'h02C;
      rem_dw = 110; begin_xfer();
      while (rem_dw != 0) begin
        decide(pass == 0 ? "R5 mismatched move" : "R6 walk", got);
        if (got == 0) break;
        rem_dw = rem_dw - CNT_W'(got);
        dst_off = dst_off + OFF_W'(got * 4);
        src_off = src_off + OFF_W'(got * 4);
      end
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      int l;
      l = l_opts[$urandom_range(9)];
      set_cfg(($urandom_range(7) != 0), ($urandom_range(7) != 0), ($urandom_range(7) != 0),
              l, ($urandom_range(2) == 0) ? l : int'($urandom_range(255)), int'($urandom_range(255)));
      mem_move = $urandom_range(1);
      dst_off = OFF_W'($urandom_range(127) * 4);
      src_off = ($urandom_range(1) == 1) ? dst_off : OFF_W'($urandom_range(511));
      rem_dw = CNT_W'($urandom_range(400));
      begin_xfer();
      decide("R6 random", got);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule